// File: doc/BRIEF.md
# Core Interrupt Handoff Controller

This block sits at the front end of a processor core. It negotiates with the interrupt control unit in two phases. When the control unit offers an interrupt, the block answers in the next cycle. It either acknowledges tentatively or refuses, based on the core's global interrupt enable and on how the offered priority compares with the running priority. A tentative acknowledge stalls instruction fetch and injects a marker micro-op that carries the offered priority. The marker travels through the pipeline, so older in-flight work can drain.

The handoff ends in one of two ways:
- The marker reaches retirement. The block then sends a final accept and releases the fetch stall.
- A resolved branch mispredict disables interrupts first. The block then sends a reject and releases fetch.

An older instruction may raise an exception during the handoff. That exception does not cancel the handoff. It is recorded, and the accept pulse reports that an exception must be serviced after the interrupt returns. The pipeline itself exists only as stimulus. Only one handoff can be in progress at a time.

Top module: `irq_handoff_ctl`

## Requirements
- R1: After a synchronous reset, all outputs are 0: ack, nak, fetch_stall, inject_marker, inject_prio, accept, reject and accept_exc_deferred.
- R2: An offer sampled while idle, with irq_enable=1 and offer_prio strictly greater than cur_prio, produces a one-cycle ack in the following cycle with nak=0.
- R3: An offer sampled while idle, with irq_enable=0 or offer_prio <= cur_prio, produces a one-cycle nak in the following cycle. There is no ack, no stall and no marker.
- R4: In the ack cycle, inject_marker pulses for one cycle. From that cycle on, inject_prio holds the acknowledged offer_prio until the next ack.
- R5: fetch_stall rises in the ack cycle. It stays 1 until the cycle in which accept or reject pulses, and it is 0 in that cycle.
- R6: marker_retire sampled during a handoff produces a one-cycle accept in the following cycle and ends the handoff.
- R7: mispredict_disable sampled during a handoff produces a one-cycle reject in the following cycle and ends the handoff. If it coincides with marker_retire, reject wins and no accept is sent.
- R8: An offer sampled while a handoff is in progress is refused with nak in the following cycle, and the handoff continues unchanged. This includes an offer sampled in the cycle that ends the handoff.
- R9: exc_flush sampled during a handoff does not end it. The next accept then carries accept_exc_deferred=1. The flag is 0 on accept when no exception occurred, and it is cleared when the handoff ends.
- R10: Each ack is followed by exactly one accept or one reject, never both. marker_retire, mispredict_disable and exc_flush are ignored while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| offer_valid | input | 1 | Interrupt offer from control unit |
| offer_prio | input | PRIO_W | Priority of the offered interrupt |
| irq_enable | input | 1 | Core global interrupt enable |
| cur_prio | input | PRIO_W | Priority the core is running at |
| marker_retire | input | 1 | Marker micro-op reached retirement |
| mispredict_disable | input | 1 | Resolved mispredict disabled interrupts |
| exc_flush | input | 1 | Older instruction raised an exception |
| ack | output | 1 | Tentative acknowledge pulse |
| nak | output | 1 | Refusal pulse |
| accept | output | 1 | Final accept pulse |
| reject | output | 1 | Withdrawal pulse |
| accept_exc_deferred | output | 1 | With accept: exception to service after return |
| fetch_stall | output | 1 | Stall instruction fetch |
| inject_marker | output | 1 | Inject marker micro-op pulse |
| inject_prio | output | PRIO_W | Priority carried by the marker |

## Verification
The bench aims at four corner cases:
- **Equal priority.** An offer whose priority equals the running priority must be refused. A design with the wrong comparison would stall fetch for an interrupt that cannot preempt.
- **Retire and mispredict together.** When both arrive in the same cycle, only reject may follow. A design with the wrong precedence would send accept, or send both pulses.
- **Offers while busy.** These include an offer in the very cycle the handoff closes. A design that frees its busy state too early would ack twice for one handoff.
- **Exceptions.** An exception during the handoff must neither end it nor be lost from the accept. Strobes while idle must produce no pulse at all.

// File: rtl/irq_handoff_pkg.sv
package irq_handoff_pkg;
  typedef enum logic [0:0] {
    HS_IDLE = 1'b0,
    HS_WAIT = 1'b1
  } hs_state_t;
endpackage

// File: rtl/offer_filter.sv
module offer_filter #(
  parameter int PRIO_W = 4
) (
  input  logic              irq_enable,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  output logic              may_take
);
  always_comb begin
    may_take = irq_enable && (offer_prio > cur_prio);
  end
endmodule

// File: rtl/exc_defer.sv
module exc_defer (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic exc_flush,
  input  logic close,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
    end else if (close || !busy) begin
      pending <= 1'b0;
    end else if (exc_flush) begin
      pending <= 1'b1;
    end
  end

  AST_PEND_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    pending |-> busy); // R9
endmodule

// File: rtl/handoff_fsm.sv
module handoff_fsm
  import irq_handoff_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              offer_valid,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic              may_take,
  input  logic              marker_retire,
  input  logic              mispredict_disable,
  input  logic              exc_flush,
  input  logic              exc_pending,
  output logic              busy,
  output logic              close,
  output logic              ack,
  output logic              nak,
  output logic              accept,
  output logic              reject,
  output logic              accept_exc_deferred,
  output logic              inject_marker,
  output logic [PRIO_W-1:0] inject_prio
);
  hs_state_t state_q;
  logic      take_now;
  logic      end_acc;
  logic      end_rej;

  assign busy = (state_q == HS_WAIT);

  always_comb begin
    end_rej  = busy && mispredict_disable;
    end_acc  = busy && !mispredict_disable && marker_retire;
    close    = end_rej || end_acc;
    take_now = !busy && offer_valid && may_take;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q             <= HS_IDLE;
      ack                 <= 1'b0;
      nak                 <= 1'b0;
      accept              <= 1'b0;
      reject              <= 1'b0;
      accept_exc_deferred <= 1'b0;
      inject_marker       <= 1'b0;
      inject_prio         <= '0;
    end else begin
      ack                 <= take_now;
      nak                 <= offer_valid && !take_now;
      inject_marker       <= take_now;
      accept              <= end_acc;
      reject              <= end_rej;
      accept_exc_deferred <= end_acc && (exc_pending || exc_flush);
      if (take_now) begin
        state_q     <= HS_WAIT;
        inject_prio <= offer_prio;
      end else if (close) begin
        state_q <= HS_IDLE;
      end
    end
  end

  AST_ACK_NAK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ack && nak)); // R2
  AST_ACK_STALLS: assert property (@(posedge clk) disable iff (rst)
    ack |-> (busy && inject_marker)); // R4
  AST_ONE_END: assert property (@(posedge clk) disable iff (rst)
    !(accept && reject)); // R10
  AST_END_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (accept || reject) |-> !busy); // R5
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (rst)
    (busy && offer_valid) |=> (nak && !ack)); // R8
  AST_END_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    (accept || reject) |-> $past(busy)); // R10
  AST_DEFER_WITH_ACC: assert property (@(posedge clk) disable iff (rst)
    accept_exc_deferred |-> accept); // R9
endmodule

// File: rtl/irq_handoff_ctl.sv
module irq_handoff_ctl #(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              offer_valid,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic              irq_enable,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              marker_retire,
  input  logic              mispredict_disable,
  input  logic              exc_flush,
  output logic              ack,
  output logic              nak,
  output logic              accept,
  output logic              reject,
  output logic              accept_exc_deferred,
  output logic              fetch_stall,
  output logic              inject_marker,
  output logic [PRIO_W-1:0] inject_prio
);
  logic may_take;
  logic busy;
  logic close;
  logic exc_pending;

  offer_filter #(.PRIO_W(PRIO_W)) u_filter (
    .irq_enable (irq_enable),
    .offer_prio (offer_prio),
    .cur_prio   (cur_prio),
    .may_take   (may_take)
  );

  exc_defer u_defer (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .exc_flush (exc_flush),
    .close     (close),
    .pending   (exc_pending)
  );

  handoff_fsm #(.PRIO_W(PRIO_W)) u_fsm (
    .clk                 (clk),
    .rst                 (rst),
    .offer_valid         (offer_valid),
    .offer_prio          (offer_prio),
    .may_take            (may_take),
    .marker_retire       (marker_retire),
    .mispredict_disable  (mispredict_disable),
    .exc_flush           (exc_flush),
    .exc_pending         (exc_pending),
    .busy                (busy),
    .close               (close),
    .ack                 (ack),
    .nak                 (nak),
    .accept              (accept),
    .reject              (reject),
    .accept_exc_deferred (accept_exc_deferred),
    .inject_marker       (inject_marker),
    .inject_prio         (inject_prio)
  );

  assign fetch_stall = busy;

  AST_NAK_NO_STALL_START: assert property (@(posedge clk) disable iff (rst)
    (nak && !$past(busy)) |-> !fetch_stall); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fetch_stall && !marker_retire && !mispredict_disable) |=> fetch_stall); // R5
endmodule

// File: tb/tb_irq_handoff_ctl.sv
module tb_irq_handoff_ctl;
  localparam int PW = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic offer_valid = 0, irq_enable = 0, marker_retire = 0;
  logic mispredict_disable = 0, exc_flush = 0;
  logic [PW-1:0] offer_prio = '0, cur_prio = '0;
  logic ack, nak, accept, reject, accept_exc_deferred;
  logic fetch_stall, inject_marker;
  logic [PW-1:0] inject_prio;

  int n_cmp = 0, n_bad = 0;
  int n_ack = 0, n_end = 0;

  // model state
  bit m_busy, m_exc, e_ack, e_nak, e_acc, e_rej, e_def, e_inj;
  int e_prio;

  always #2.5 clk = ~clk;

  irq_handoff_ctl #(.PRIO_W(PW)) dut (
    .clk(clk), .rst(rst), .offer_valid(offer_valid), .offer_prio(offer_prio),
    .irq_enable(irq_enable), .cur_prio(cur_prio), .marker_retire(marker_retire),
    .mispredict_disable(mispredict_disable), .exc_flush(exc_flush),
    .ack(ack), .nak(nak), .accept(accept), .reject(reject),
    .accept_exc_deferred(accept_exc_deferred), .fetch_stall(fetch_stall),
    .inject_marker(inject_marker), .inject_prio(inject_prio));

  // behavioural reference, updated at each edge
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_exc = 0; e_ack = 0; e_nak = 0; e_acc = 0;
      e_rej = 0; e_def = 0; e_inj = 0; e_prio = 0;
    end else begin
      e_ack = 0; e_nak = 0; e_acc = 0; e_rej = 0; e_def = 0; e_inj = 0;
      if (m_busy) begin
        if (offer_valid) e_nak = 1;
        if (mispredict_disable) begin
          e_rej = 1; m_busy = 0; m_exc = 0;
        end else if (marker_retire) begin
          e_acc = 1; e_def = m_exc || exc_flush; m_busy = 0; m_exc = 0;
        end else if (exc_flush) begin
          m_exc = 1;
        end
      end else if (offer_valid) begin
        if (irq_enable && int'(offer_prio) > int'(cur_prio)) begin
          e_ack = 1; e_inj = 1; m_busy = 1; m_exc = 0; e_prio = int'(offer_prio);
        end else begin
          e_nak = 1;
        end
      end
    end
  end

  task automatic cmp(input string tag, input string nm, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cmp("R2", "ack", int'(ack), int'(e_ack));
      cmp("R3", "nak", int'(nak), int'(e_nak));
      cmp("R4", "inject_marker", int'(inject_marker), int'(e_inj));
      cmp("R4", "inject_prio", int'(inject_prio), e_prio);
      cmp("R5", "fetch_stall", int'(fetch_stall), int'(m_busy));
      cmp("R6", "accept", int'(accept), int'(e_acc));
      cmp("R7", "reject", int'(reject), int'(e_rej));
      cmp("R9", "accept_exc_deferred", int'(accept_exc_deferred), int'(e_def));
      cmp("R10", "both_ends", int'(accept && reject), 0);
      if (ack) n_ack++;
      if (accept || reject) n_end++;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_in();
    offer_valid = 0; marker_retire = 0; mispredict_disable = 0; exc_flush = 0;
  endtask

  task automatic offer(input int p);
    offer_valid = 1; offer_prio = PW'(p); tick(); offer_valid = 0;
  endtask

  task automatic pulse_retire();   marker_retire = 1; tick(); marker_retire = 0; endtask
  task automatic pulse_mis();      mispredict_disable = 1; tick(); mispredict_disable = 0; endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    // R1: reset values
    cmp("R1", "reset_outs", int'({ack, nak, accept, reject, accept_exc_deferred,
        fetch_stall, inject_marker}), 0);
    cmp("R1", "reset_prio", int'(inject_prio), 0);
    tick(2);
    irq_enable = 1; cur_prio = 4'd5;
    // R10: idle strobes ignored
    marker_retire = 1; mispredict_disable = 1; exc_flush = 1; tick(); clear_in(); tick(2);
    // R3: equal priority refused, lower refused, disabled refused
    offer(5); tick(2);
    offer(2); tick(2);
    irq_enable = 0; offer(12); tick(2); irq_enable = 1;
    // R2/R4/R6: accept path
    offer(9); tick(3); pulse_retire(); tick(2);
    // R7: mispredict withdraws
    offer(7); tick(2); pulse_mis(); tick(2);
    // R7: simultaneous retire and mispredict -> reject
    offer(6); tick(1);
    marker_retire = 1; mispredict_disable = 1; tick(); clear_in(); tick(2);
    // R8: offers while busy refused, including on the closing cycle
    offer(10); offer(15); tick(1); offer(14);
    offer_valid = 1; offer_prio = 4'd13; marker_retire = 1; tick(); clear_in();
    tick(2);
    // R9: exception during handoff, deferred flag on accept
    offer(11); tick(1); exc_flush = 1; tick(); exc_flush = 0; tick(2);
    cmp("R9", "stall_after_exc", int'(fetch_stall), 1);
    pulse_retire(); tick(2);
    // R9: exception same cycle as retire, then a clean accept afterwards
    offer(8); exc_flush = 1; marker_retire = 1; tick(); clear_in(); tick(2);
    offer(8); tick(1); pulse_retire(); tick(2);
    // R9: exception then reject clears flag; next accept clean
    offer(9); exc_flush = 1; tick(); exc_flush = 0; pulse_mis(); tick(1);
    offer(9); pulse_retire(); tick(2);
    // back-to-back offers after close
    cur_prio = 4'd0;
    for (int k = 1; k < 16; k++) begin
      offer(k);
      if (k % 3 == 0) pulse_mis(); else pulse_retire();
    end
    tick(3);
    // R10: one end per ack
    cmp("R10", "ack_vs_end", n_end, n_ack);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule